// File: doc/BRIEF.md
# Receive Frame Word Store

This block holds received CAN FD frames until the host fetches them. A receiver upstream delivers each frame as a run of 32-bit words, marked by a write strobe, and ends the run with either a commit strobe (keep the frame) or an abort strobe (throw it away). Words land in a circular word memory at a provisional write position and only join the readable contents once the frame is committed, so a frame broken off mid-way never becomes visible.

Every stored frame describes itself. Its first word is the format word, which carries the frame flags, the length code and a word count; then come the identifier word, two timestamp words and the payload words. The host pops words one at a time through a single data port. The read side decodes the word count from each format word, so it knows where each frame ends and lowers the frame count as the last word leaves. When no frame is stored, the data port returns an all-zero word, whose word-count field is therefore zero. A frame that does not fit in the free space is dropped whole, and a sticky overrun flag records the loss until the host clears it.

Top module: `rxf_frame_store`

## Requirements
- R1: After reset, frame_count is 0, overrun is 0, rx_ready is 0 and rd_data is all zeros.
- R2: While frame_count is 0, rd_data is all zeros and a read request is ignored: the next committed frame reads out from its first word.
- R3: Words written and then committed read out on rd_data in the order they were written, one word per accepted read request. frame_count rises by one in the cycle after the commit. A commit may come in the same cycle as the frame's last word.
- R4: Words written without a commit are invisible: frame_count stays 0 and rd_data stays zero. A later commit alone, with no word in the same cycle, publishes them.
- R5: An abort discards every word of the pending frame. When abort and commit come in the same cycle, the abort wins.
- R6: Bits 4:0 of the format word hold the word count, which is the number of payload words plus three. The frame ends after the format word and that many further words have been read. frame_count drops by one in the cycle after the last word is read.
- R7: rx_ready is high exactly when frame_count is nonzero.
- R8: A frame whose words exceed the free space is lost whole when it is committed. overrun goes high, frame_count is unchanged, and the frames stored earlier read out intact.
- R9: A clr_overrun pulse clears overrun. If a frame is lost in the same cycle, overrun stays set.
- R10: If a commit and the read of a frame's last word fall in the same cycle, frame_count keeps its value and both frames stay consistent.
- R11: A commit with no pending words is ignored, and frame_count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Frame word strobe from the receiver |
| wr_word | input | 32 | Frame word |
| wr_commit | input | 1 | Keeps the pending frame, including any word written in the same cycle |
| wr_abort | input | 1 | Discards the pending frame |
| rd_req | input | 1 | Pops the word shown on rd_data |
| rd_data | output | 32 | Word at the read position, or zero when no frame is stored |
| clr_overrun | input | 1 | Clears the overrun flag |
| frame_count | output | clog2(DEPTH_WORDS)+1 | Number of complete frames stored |
| overrun | output | 1 | Sticky flag: a frame was lost for lack of space |
| rx_ready | output | 1 | High while at least one frame is stored |

## Verification
Two pairs of events can coincide and are forced into one cycle on purpose. In the first, the receiver commits a frame with its final word while the host reads the last word of the older frame; frame_count must then hold its value, and both frames must read out correctly afterwards. In the second, an oversized frame is committed, and so lost, in the same cycle as a clr_overrun pulse; the flag must read set afterwards, and only a separate later pulse may clear it.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int WORD_W   = 32;
    localparam int WCNT_LSB = 0;
    localparam int WCNT_W   = 5;
endpackage

// File: rtl/rxf_word_ram.sv
module rxf_word_ram #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [rxf_pkg::WORD_W-1:0] wdata,
    input  logic [AW-1:0]             raddr,
    output logic [rxf_pkg::WORD_W-1:0] rdata
);
    logic [rxf_pkg::WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rxf_write_ctl.sv
module rxf_write_ctl #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          wr_commit,
    input  logic          wr_abort,
    input  logic [PW-1:0] rptr,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic          frame_ok,
    output logic          frame_lost
);
    typedef struct packed {
        logic [PW-1:0] tmp;   // provisional write position
        logic [PW-1:0] base;  // end of committed contents
        logic          drop;  // pending frame already lost
    } wst_t;

    wst_t q, d;
    logic [PW-1:0] used;
    logic          full;
    logic          accept;

    assign used      = q.tmp - rptr;
    assign full      = (used == PW'(DEPTH));
    assign ram_waddr = q.tmp[AW-1:0];

    always_comb begin
        d          = q;
        ram_we     = 1'b0;
        frame_ok   = 1'b0;
        frame_lost = 1'b0;
        accept     = wr_valid && !q.drop && !full && !wr_abort;
        if (accept) begin
            ram_we = 1'b1;
            d.tmp  = q.tmp + PW'(1);
        end
        if (wr_valid && !q.drop && full && !wr_abort) d.drop = 1'b1;
        if (wr_abort) begin
            d.tmp  = q.base;
            d.drop = 1'b0;
        end else if (wr_commit) begin
            if (d.drop) begin
                frame_lost = 1'b1;
                d.tmp      = q.base;
                d.drop     = 1'b0;
            end else if (d.tmp != q.base) begin
                frame_ok = 1'b1;
                d.base   = d.tmp;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_abort_rollback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_abort |=> (q.tmp == q.base));
    assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.tmp - rptr) <= PW'(DEPTH));
    assert_lost_not_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_lost |-> !frame_ok);
endmodule

// File: rtl/rxf_read_ctl.sv
module rxf_read_ctl #(
    parameter int AW = 5,
    parameter int PW = AW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_req,
    input  logic                      avail,
    input  logic [rxf_pkg::WCNT_W-1:0] wcnt,
    output logic [PW-1:0]             rptr,
    output logic                      frame_done
);
    typedef struct packed {
        logic [PW-1:0]              rptr;
        logic [rxf_pkg::WCNT_W-1:0] left;  // words still to read in this frame
    } rst_t;

    rst_t q, d;
    logic pop;

    assign rptr = q.rptr;

    always_comb begin
        d          = q;
        frame_done = 1'b0;
        pop        = rd_req && avail;
        if (pop) begin
            d.rptr = q.rptr + PW'(1);
            if (q.left == '0) begin
                if (wcnt == '0) frame_done = 1'b1;
                else            d.left     = wcnt;
            end else begin
                d.left = q.left - 1'b1;
                if (q.left == rxf_pkg::WCNT_W'(1)) frame_done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_empty_read_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !avail) |=> $stable(q.rptr));
    assert_frame_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (q.left == '0));
endmodule

// File: rtl/rxf_status.sv
module rxf_status #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_ok,
    input  logic          frame_done,
    input  logic          frame_lost,
    input  logic          clr_ovr,
    output logic [CW-1:0] count,
    output logic          overrun
);
    typedef struct packed {
        logic [CW-1:0] count;
        logic          ovr;
    } sst_t;

    sst_t q, d;

    always_comb begin
        d = q;
        if (frame_ok && !frame_done)      d.count = q.count + CW'(1);
        else if (frame_done && !frame_ok) d.count = q.count - CW'(1);
        if (frame_lost)   d.ovr = 1'b1;
        else if (clr_ovr) d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count   = q.count;
    assign overrun = q.ovr;

    assert_ovr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_lost |=> q.ovr);
    assert_ovr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovr && !frame_lost) |=> !q.ovr);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (q.count != '0));
    assert_net_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && frame_done) |=> $stable(q.count));
endmodule

// File: rtl/rxf_frame_store.sv
module rxf_frame_store #(
    parameter int DEPTH_WORDS = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_valid,
    input  logic [31:0]                    wr_word,
    input  logic                           wr_commit,
    input  logic                           wr_abort,
    input  logic                           rd_req,
    output logic [31:0]                    rd_data,
    input  logic                           clr_overrun,
    output logic [$clog2(DEPTH_WORDS):0]   frame_count,
    output logic                           overrun,
    output logic                           rx_ready
);
    localparam int AW = $clog2(DEPTH_WORDS);
    localparam int PW = AW + 1;

    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [31:0]   ram_rdata;
    logic [PW-1:0] rptr;
    logic          frame_ok, frame_lost, frame_done;
    logic          avail;

    assign avail    = (frame_count != '0);
    assign rx_ready = avail;
    assign rd_data  = avail ? ram_rdata : '0;

    rxf_word_ram #(.DEPTH(DEPTH_WORDS), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (wr_word),
        .raddr (rptr[AW-1:0]),
        .rdata (ram_rdata)
    );

    rxf_write_ctl #(.DEPTH(DEPTH_WORDS), .AW(AW), .PW(PW)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_commit  (wr_commit),
        .wr_abort   (wr_abort),
        .rptr       (rptr),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .frame_ok   (frame_ok),
        .frame_lost (frame_lost)
    );

    rxf_read_ctl #(.AW(AW), .PW(PW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .avail      (avail),
        .wcnt       (ram_rdata[rxf_pkg::WCNT_LSB +: rxf_pkg::WCNT_W]),
        .rptr       (rptr),
        .frame_done (frame_done)
    );

    rxf_status #(.CW(PW)) u_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_ok   (frame_ok),
        .frame_done (frame_done),
        .frame_lost (frame_lost),
        .clr_ovr    (clr_overrun),
        .count      (frame_count),
        .overrun    (overrun)
    );
endmodule

// File: tb/rxf_frame_store_test.sv
module rxf_frame_store_test;
    localparam int DEPTH = 32;
    localparam int NT = 6;
    localparam int TBL_N [NT] = '{0, 1, 2, 5, 8, 16};
    localparam int TBL_S [NT] = '{11'h123, 11'h7FF, 11'h001, 11'h2AA, 11'h555, 11'h0F0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, wr_commit = 1'b0, wr_abort = 1'b0;
    logic [31:0] wr_word = '0;
    logic        rd_req = 1'b0, clr_overrun = 1'b0;
    logic [31:0] rd_data;
    logic [5:0]  frame_count;
    logic        overrun, rx_ready;
    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    rxf_frame_store #(.DEPTH_WORDS(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
        .wr_commit(wr_commit), .wr_abort(wr_abort), .rd_req(rd_req),
        .rd_data(rd_data), .clr_overrun(clr_overrun), .frame_count(frame_count),
        .overrun(overrun), .rx_ready(rx_ready)
    );

    function automatic logic [31:0] gen(input int n, input int seed, input int i);
        logic [31:0] s;
        s = 32'(seed);
        if (i == 0)      return 32'h5A00_0000 | (s << 8) | 32'(n + 3);
        else if (i == 1) return {3'b000, s[10:0], 18'h0};
        else if (i < 4)  return 32'h7000_0000 + (s << 4) + 32'(i);
        else             return 32'hD000_0000 | (s << 12) | 32'(i);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_frame(input int n, input int seed, input bit commit);
        for (int i = 0; i < n + 4; i++) begin
            wr_valid  = 1'b1;
            wr_word   = gen(n, seed, i);
            wr_commit = commit && (i == n + 3);
            @(negedge clk);
        end
        wr_valid = 1'b0; wr_commit = 1'b0;
    endtask

    task automatic pop_check(input string req, input logic [31:0] exp);
        chk(req, rd_data, exp);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic read_frame(input string req, input int n, input int seed);
        for (int i = 0; i < n + 4; i++) pop_check(req, gen(n, seed, i));
    endtask

    task automatic pulse_commit();
        wr_commit = 1'b1; @(negedge clk); wr_commit = 1'b0;
    endtask

    task automatic pulse_clear();
        clr_overrun = 1'b1; @(negedge clk); clr_overrun = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", 32'(frame_count), 0);
        chk("R1 overrun", 32'(overrun), 0);
        chk("R1 ready", 32'(rx_ready), 0);
        chk("R1 data", rd_data, 0);

        // R2 empty read returns zero and is ignored
        pop_check("R2 empty data", 32'h0);
        chk("R2 count", 32'(frame_count), 0);

        // R3 R6 R7 table walk
        for (int t = 0; t < NT; t++) begin
            write_frame(TBL_N[t], TBL_S[t], 1'b1);
            chk("R3 count after commit", 32'(frame_count), 1);
            chk("R7 ready", 32'(rx_ready), 1);
            chk("R6 wcnt field", 32'(rd_data[4:0]), 32'(TBL_N[t] + 3));
            read_frame("R3 word", TBL_N[t], TBL_S[t]);
            chk("R6 count after last", 32'(frame_count), 0);
            chk("R7 ready low", 32'(rx_ready), 0);
        end

        // R4 uncommitted words invisible, commit alone publishes
        write_frame(2, 11'h3C3, 1'b0);
        chk("R4 count", 32'(frame_count), 0);
        chk("R4 data", rd_data, 0);
        pulse_commit();
        chk("R4 count after commit", 32'(frame_count), 1);
        read_frame("R4 word", 2, 11'h3C3);

        // R11 empty commit ignored
        pulse_commit();
        chk("R11 count", 32'(frame_count), 0);

        // R5 abort, and abort beating commit
        write_frame(3, 11'h111, 1'b0);
        wr_abort = 1'b1; @(negedge clk); wr_abort = 1'b0;
        chk("R5 count after abort", 32'(frame_count), 0);
        write_frame(1, 11'h222, 1'b0);
        wr_abort = 1'b1; wr_commit = 1'b1; @(negedge clk);
        wr_abort = 1'b0; wr_commit = 1'b0;
        chk("R5 abort wins", 32'(frame_count), 0);
        chk("R5 data", rd_data, 0);
        write_frame(2, 11'h333, 1'b1);
        read_frame("R5 next frame", 2, 11'h333);

        // queued frames
        write_frame(0, 11'h010, 1'b1);
        write_frame(1, 11'h020, 1'b1);
        write_frame(2, 11'h030, 1'b1);
        chk("R3 three queued", 32'(frame_count), 3);
        read_frame("R3 queued a", 0, 11'h010);
        chk("R6 count two", 32'(frame_count), 2);
        read_frame("R3 queued b", 1, 11'h020);
        read_frame("R3 queued c", 2, 11'h030);
        chk("R6 count zero", 32'(frame_count), 0);

        // R8 overflow drops a whole frame
        write_frame(16, 11'h4A4, 1'b1);
        write_frame(16, 11'h5B5, 1'b1);
        chk("R8 overrun", 32'(overrun), 1);
        chk("R8 count kept", 32'(frame_count), 1);
        read_frame("R8 earlier intact", 16, 11'h4A4);
        chk("R8 count zero", 32'(frame_count), 0);

        // R9 clear, then lost frame in same cycle as clear
        pulse_clear();
        chk("R9 cleared", 32'(overrun), 0);
        write_frame(16, 11'h606, 1'b1);
        for (int i = 0; i < 20; i++) begin
            wr_valid = 1'b1; wr_word = gen(16, 11'h707, i);
            wr_commit = (i == 19); clr_overrun = (i == 19);
            @(negedge clk);
        end
        wr_valid = 1'b0; wr_commit = 1'b0; clr_overrun = 1'b0;
        chk("R9 set wins over clear", 32'(overrun), 1);
        read_frame("R9 survivor", 16, 11'h606);
        pulse_clear();
        chk("R9 later clear", 32'(overrun), 0);

        // R10 commit and last-word read in the same cycle
        write_frame(0, 11'h0AA, 1'b1);
        for (int i = 0; i < 4; i++) begin
            wr_valid = 1'b1; wr_word = gen(1, 11'h0BB, i); @(negedge clk);
        end
        wr_valid = 1'b0;
        for (int i = 0; i < 3; i++) pop_check("R10 older", gen(0, 11'h0AA, i));
        chk("R10 older last", rd_data, gen(0, 11'h0AA, 3));
        wr_valid = 1'b1; wr_word = gen(1, 11'h0BB, 4); wr_commit = 1'b1; rd_req = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; wr_commit = 1'b0; rd_req = 1'b0;
        chk("R10 count held", 32'(frame_count), 1);
        read_frame("R10 newer", 1, 11'h0BB);
        chk("R10 count zero", 32'(frame_count), 0);

        summary();
        $finish;
    end
endmodule